// File: doc/BRIEF.md
# PCIe Link Glue Register Bank

This block is a small register bank on an APB port that sits next to a PCIe controller core. It holds the settings that steer the core: the device mode, the link-training enable, the clock-request controls and the hot-reset handling. It also shows status coming back from the core: the legacy INTx lines, latched link events, residency in the L1 substates, and the training-state and link word. Every writable control register uses halfword write enables. Bits 31:16 of the write data choose which of bits 15:0 change, so software can update one field without reading the register first.

The interrupt line is a level signal. It is the OR of every INTx status bit and every latched event bit whose mask is clear. The event bits set on a rising edge from the core. They stay set until software writes back the bits it read.

When delayed training is enabled, a hot-reset or link-down request holds link training off. The hold stays on until software writes a self-clearing acknowledge bit. The training enable sent to the core is the software enable gated by that hold.

Top module: `pcie_glue_regs`

## Requirements
- R1: A write to a control register (offsets 0x000, 0x01C, 0x024, 0x02C, 0x180) changes data bit i (i < 16) only when bit i+16 of the same write is 1. Bits whose enable is 0 keep their value.
- R2: Offset 0x000 holds the device mode in bits 7:4 (driven on `dev_mode`; 0 = endpoint, 4 = root complex) and the training enable in bit 2 (driven on `ltssm_en`). All bits reset to 0.
- R3: Offset 0x008 reads the live `intx_in` lines in bits 3:0. Offset 0x01C is the INTx mask in bits 7:0 and resets to 0xFF. Writing a bit together with its enable masks it; writing the enable alone unmasks it.
- R4: `irq` is high exactly when some `intx_in[i]` is high with mask bit i clear, or some event status bit (1 or 2) is set with the matching bit of the 0x024 mask clear.
- R5: Offset 0x010 bit 1 latches a rising edge of `evt_link_chg`, and bit 2 latches a rising edge of `evt_rst_req`. A set bit stays set until a write to 0x010 with a 1 in that bit position, with no enable needed. When a rising edge and a clear meet in the same cycle, the bit ends up set. The mask at 0x024 resets to 0xFFFF.
- R6: Offset 0x300 reads `ltssm_state` in bits 5:0 and `link_bits` in bits 17:16. `link_up` is high only when both link bits are 1.
- R7: Offset 0x180 holds the delayed-training enable in bit 1 (`dly_train_en`) and the enhanced-enable control in bit 4 (`enh_ltssm_en`). Bit 3 always reads 0. While bit 1 is set, a rising `evt_rst_req` raises `train_hold` in the next cycle. `ltssm_go` equals `ltssm_en` AND NOT `train_hold`.
- R8: A write to 0x180 with bits 3 and 19 both set drops `train_hold` in the next cycle, unless a new held reset request arrives in that same cycle, in which case the hold stays on.
- R9: Offset 0x02C holds the clock-request ready bit in bit 0 (`clkreq_ready`) and the pull-down field in bits 13:12 (`clkreq_pd`), reset 0. Offset 0x154 reads `l1_1_res` in bit 4 and `l1_2_res` in bit 5.
- R10: `pready` is always 1. Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| intx_in | input | NUM_INTX | Legacy INTx levels from the core |
| evt_link_chg | input | 1 | Link-up change event from the core |
| evt_rst_req | input | 1 | Hot-reset / link-down reset request from the core |
| ltssm_state | input | LTSSM_W | Training state from the core |
| link_bits | input | 2 | Link status bits from the core |
| l1_1_res | input | 1 | L1.1 residency indicator |
| l1_2_res | input | 1 | L1.2 residency indicator |
| dev_mode | output | 4 | Device mode field |
| ltssm_en | output | 1 | Software training enable |
| ltssm_go | output | 1 | Training enable after the reset hold |
| train_hold | output | 1 | Training held after a reset request |
| link_up | output | 1 | Both link bits set |
| clkreq_ready | output | 1 | Clock-request ready control |
| clkreq_pd | output | 2 | Clock-request pull-down field |
| dly_train_en | output | 1 | Delayed-training enable |
| enh_ltssm_en | output | 1 | Enhanced training-enable control |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions can happen in the same cycle. A software clear of an event bit can arrive together with a fresh rising edge on that event. A training-hold acknowledge can arrive together with a new reset request. The bench provokes each collision by timing an event pulse so that it rises exactly on the edge that commits the APB write, both in directed steps and in a long run of random writes and event toggles. A behavioural model in which the set wins over the clear judges the outcome, by comparing `irq`, `train_hold`, `ltssm_go` and the read-back status on every clock.

// File: rtl/pglue_pkg.sv
package pglue_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_INTX_ST  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_EVT_ST   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_INTX_MSK = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_EVT_MSK  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_PWR      = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_L1_RES   = 12'h154;
  localparam logic [ADDR_W-1:0] OFS_HRST     = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_LINK     = 12'h300;
  localparam int HALF_W   = 16;
  localparam int NUM_EVT  = 2;
  localparam int EVT_LSB  = 1;
  localparam int HRST_DONE_BIT = 3;
endpackage

// File: rtl/pglue_wm_reg.sv
module pglue_wm_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] bit_en,
  input  logic [W-1:0] bit_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = (q & ~bit_en) | (bit_val & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  AST_WM_UNENABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(bit_en)) == '0)); // R1
  AST_WM_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R1
endmodule

// File: rtl/pglue_evt_stat.sv
module pglue_evt_stat #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] st,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  logic [N-1:0] st_nxt;
  logic [N-1:0] clr_eff;

  assign rise = evt_in & ~prev_q;

  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
    st_nxt  = (st & ~clr_eff) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      st     <= '0;
    end else begin
      prev_q <= evt_in;
      st     <= st_nxt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in[g] && !prev_q[g]) |=> st[g]); // R5
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] && !(clr_en && clr_bits[g])) |=> st[g]); // R5
  end
endmodule

// File: rtl/pglue_hold.sv
module pglue_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic dly_en,
  input  logic req_rise,
  input  logic done_wr,
  output logic hold
);
  logic hold_nxt;
  logic arm;

  assign arm = dly_en & req_rise;

  always_comb begin
    hold_nxt = hold;
    if (done_wr) hold_nxt = 1'b0;
    if (arm)     hold_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= hold_nxt;
  end

  AST_HOLD_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_en && req_rise) |=> hold); // R7
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && !(dly_en && req_rise)) |=> !hold); // R8
  AST_HOLD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !(dly_en && req_rise)) |=> !hold); // R7
endmodule

// File: rtl/pcie_glue_regs.sv
module pcie_glue_regs
  import pglue_pkg::*;
#(
  parameter int NUM_INTX = 4,
  parameter int LTSSM_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  output logic                pready,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic                evt_link_chg,
  input  logic                evt_rst_req,
  input  logic [LTSSM_W-1:0]  ltssm_state,
  input  logic [1:0]          link_bits,
  input  logic                l1_1_res,
  input  logic                l1_2_res,
  output logic [3:0]          dev_mode,
  output logic                ltssm_en,
  output logic                ltssm_go,
  output logic                train_hold,
  output logic                link_up,
  output logic                clkreq_ready,
  output logic [1:0]          clkreq_pd,
  output logic                dly_train_en,
  output logic                enh_ltssm_en,
  output logic                irq
);
  localparam int IMSK_W = 8;

  logic              wr;
  logic              wr_ctrl, wr_imsk, wr_emsk, wr_pwr, wr_hrst, wr_est;
  logic [HALF_W-1:0] ctrl_q, emsk_q, pwr_q, hrst_q;
  logic [IMSK_W-1:0] imsk_q;
  logic [HALF_W-1:0] hrst_en;
  logic              done_wr;
  logic [NUM_EVT-1:0] evt_st, evt_rise;
  logic [31:0]       rd;

  assign wr      = psel & penable & pwrite;
  assign wr_ctrl = wr & (paddr == OFS_CTRL);
  assign wr_imsk = wr & (paddr == OFS_INTX_MSK);
  assign wr_emsk = wr & (paddr == OFS_EVT_MSK);
  assign wr_pwr  = wr & (paddr == OFS_PWR);
  assign wr_hrst = wr & (paddr == OFS_HRST);
  assign wr_est  = wr & (paddr == OFS_EVT_ST);
  assign pready  = 1'b1;

  // the acknowledge bit is a strobe, never stored
  assign hrst_en = pwdata[HALF_W +: HALF_W] & ~(HALF_W'(1) << HRST_DONE_BIT);
  assign done_wr = wr_hrst & pwdata[HALF_W + HRST_DONE_BIT] & pwdata[HRST_DONE_BIT];

  pglue_wm_reg #(.W(HALF_W), .RST_VAL('0)) u_ctrl (
    .clk, .rst_n, .wr_en(wr_ctrl), .bit_en(pwdata[HALF_W +: HALF_W]),
    .bit_val(pwdata[HALF_W-1:0]), .q(ctrl_q));
  pglue_wm_reg #(.W(IMSK_W), .RST_VAL('1)) u_imsk (
    .clk, .rst_n, .wr_en(wr_imsk), .bit_en(pwdata[HALF_W +: IMSK_W]),
    .bit_val(pwdata[IMSK_W-1:0]), .q(imsk_q));
  pglue_wm_reg #(.W(HALF_W), .RST_VAL('1)) u_emsk (
    .clk, .rst_n, .wr_en(wr_emsk), .bit_en(pwdata[HALF_W +: HALF_W]),
    .bit_val(pwdata[HALF_W-1:0]), .q(emsk_q));
  pglue_wm_reg #(.W(HALF_W), .RST_VAL('0)) u_pwr (
    .clk, .rst_n, .wr_en(wr_pwr), .bit_en(pwdata[HALF_W +: HALF_W]),
    .bit_val(pwdata[HALF_W-1:0]), .q(pwr_q));
  pglue_wm_reg #(.W(HALF_W), .RST_VAL('0)) u_hrst (
    .clk, .rst_n, .wr_en(wr_hrst), .bit_en(hrst_en),
    .bit_val(pwdata[HALF_W-1:0]), .q(hrst_q));

  pglue_evt_stat #(.N(NUM_EVT)) u_evt (
    .clk, .rst_n, .evt_in({evt_rst_req, evt_link_chg}), .clr_en(wr_est),
    .clr_bits(pwdata[EVT_LSB +: NUM_EVT]), .st(evt_st), .rise(evt_rise));

  pglue_hold u_hold (
    .clk, .rst_n, .dly_en(hrst_q[1]), .req_rise(evt_rise[1]),
    .done_wr(done_wr), .hold(train_hold));

  assign dev_mode     = ctrl_q[7:4];
  assign ltssm_en     = ctrl_q[2];
  assign ltssm_go     = ltssm_en & ~train_hold;
  assign link_up      = &link_bits;
  assign clkreq_ready = pwr_q[0];
  assign clkreq_pd    = pwr_q[13:12];
  assign dly_train_en = hrst_q[1];
  assign enh_ltssm_en = hrst_q[4];
  assign irq = (|(intx_in & ~imsk_q[NUM_INTX-1:0])) |
               (|(evt_st & ~emsk_q[EVT_LSB +: NUM_EVT]));

  always_comb begin
    rd = '0;
    if (psel && !pwrite) begin
      unique case (paddr)
        OFS_CTRL:     rd[HALF_W-1:0]   = ctrl_q;
        OFS_INTX_ST:  rd[NUM_INTX-1:0] = intx_in;
        OFS_EVT_ST:   rd[EVT_LSB +: NUM_EVT] = evt_st;
        OFS_INTX_MSK: rd[IMSK_W-1:0]   = imsk_q;
        OFS_EVT_MSK:  rd[HALF_W-1:0]   = emsk_q;
        OFS_PWR:      rd[HALF_W-1:0]   = pwr_q;
        OFS_L1_RES:   rd[5:4]          = {l1_2_res, l1_1_res};
        OFS_HRST:     rd[HALF_W-1:0]   = hrst_q;
        OFS_LINK: begin
          rd[LTSSM_W-1:0] = ltssm_state;
          rd[17:16]       = link_bits;
        end
        default:      rd = '0;
      endcase
    end
  end
  assign prdata = rd;

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((&imsk_q[NUM_INTX-1:0]) && (&emsk_q[EVT_LSB +: NUM_EVT])) |-> !irq); // R4
  AST_GO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    train_hold |-> !ltssm_go); // R7
  AST_DONE_NEVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == OFS_HRST) |-> !prdata[HRST_DONE_BIT]); // R7
endmodule

// File: tb/pcie_glue_regs_bench.sv
module pcie_glue_regs_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [3:0]  intx_in = '0;
  logic        evt_link_chg = 1'b0, evt_rst_req = 1'b0;
  logic [5:0]  ltssm_state = '0;
  logic [1:0]  link_bits = '0;
  logic        l1_1_res = 1'b0, l1_2_res = 1'b0;
  logic [3:0]  dev_mode;
  logic        ltssm_en, ltssm_go, train_hold, link_up, clkreq_ready;
  logic [1:0]  clkreq_pd;
  logic        dly_train_en, enh_ltssm_en, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pcie_glue_regs u_pcie_glue_regs (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata, .pready,
    .intx_in, .evt_link_chg, .evt_rst_req, .ltssm_state, .link_bits,
    .l1_1_res, .l1_2_res, .dev_mode, .ltssm_en, .ltssm_go, .train_hold,
    .link_up, .clkreq_ready, .clkreq_pd, .dly_train_en, .enh_ltssm_en, .irq);

  // behavioural reference model
  logic [15:0] m_gen, m_mmask, m_pwr, m_hrc;
  logic [7:0]  m_imask;
  logic [2:1]  m_st;
  logic        m_plc, m_prr, m_hold;

  function automatic logic [15:0] wmerge(input logic [15:0] old, input logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gen = 0; m_mmask = 16'hFFFF; m_pwr = 0; m_hrc = 0; m_imask = 8'hFF;
      m_st = 0; m_plc = 0; m_prr = 0; m_hold = 0;
    end else begin
      bit rlc, rrr, w;
      rlc = evt_link_chg && !m_plc;
      rrr = evt_rst_req && !m_prr;
      w = psel && penable && pwrite;
      if (w && paddr == 12'h180 && pwdata[19] && pwdata[3]) m_hold = 0;
      if (m_hrc[1] && rrr) m_hold = 1;
      if (w && paddr == 12'h010) m_st = m_st & ~pwdata[2:1];
      if (rlc) m_st[1] = 1;
      if (rrr) m_st[2] = 1;
      if (w) begin
        case (paddr)
          12'h000: m_gen = wmerge(m_gen, pwdata);
          12'h01C: m_imask = 8'(wmerge({8'h0, m_imask}, pwdata));
          12'h024: m_mmask = wmerge(m_mmask, pwdata);
          12'h02C: m_pwr = wmerge(m_pwr, pwdata);
          12'h180: m_hrc = wmerge(m_hrc, pwdata & ~32'h0008_0008);
          default: ;
        endcase
      end
      m_plc = evt_link_chg;
      m_prr = evt_rst_req;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      12'h000: r[15:0] = m_gen;
      12'h008: r[3:0] = intx_in;
      12'h010: r[2:1] = m_st;
      12'h01C: r[7:0] = m_imask;
      12'h024: r[15:0] = m_mmask;
      12'h02C: r[15:0] = m_pwr;
      12'h154: begin r[4] = l1_1_res; r[5] = l1_2_res; end
      12'h180: r[15:0] = m_hrc;
      12'h300: begin r[5:0] = ltssm_state; r[17:16] = link_bits; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    case (a)
      12'h000: return "R2 read ctrl";
      12'h008, 12'h01C: return "R3 read intx";
      12'h010, 12'h024: return "R5 read events";
      12'h02C, 12'h154: return "R9 read power";
      12'h180: return "R7 read hot-reset";
      12'h300: return "R6 read link";
      default: return "R10 read unmapped";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic eirq;
      eirq = (|(intx_in & ~m_imask[3:0])) | (|(m_st & ~m_mmask[2:1]));
      chk(32'(irq), 32'(eirq), "R4 irq");
      chk(32'(train_hold), 32'(m_hold), "R7 train_hold");
      chk(32'(ltssm_go), 32'(m_gen[2] & ~m_hold), "R7 ltssm_go");
      chk(32'({dev_mode, ltssm_en}), 32'({m_gen[7:4], m_gen[2]}), "R2 mode/enable");
      chk(32'(link_up), 32'(&link_bits), "R6 link_up");
      chk(32'({clkreq_pd, clkreq_ready}), 32'({m_pwr[13:12], m_pwr[0]}), "R9 clkreq");
      chk(32'({enh_ltssm_en, dly_train_en}), 32'({m_hrc[4], m_hrc[1]}), "R7 hrst ctrl");
      chk(32'(pready), 32'd1, "R10 pready");
      if (psel && !pwrite) chk(prdata, m_read(paddr), rd_tag(paddr));
    end
  end

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a);
    @(posedge clk); #1;
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic pulse_link;
    @(posedge clk); #1 evt_link_chg = 1;
    @(posedge clk); #1 evt_link_chg = 0;
  endtask

  task automatic pulse_rst;
    @(posedge clk); #1 evt_rst_req = 1;
    @(posedge clk); #1 evt_rst_req = 0;
  endtask

  task automatic read_all;
    apb_read(12'h000); apb_read(12'h008); apb_read(12'h010); apb_read(12'h01C);
    apb_read(12'h024); apb_read(12'h02C); apb_read(12'h154); apb_read(12'h180);
    apb_read(12'h300); apb_read(12'h004);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!fin) begin
      fin = 1;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state of every register
    read_all();

    // R1/R2: halfword write enables on the control register
    apb_write(12'h000, 32'h00F4_0044);
    @(negedge clk); chk(32'({dev_mode, ltssm_en}), 32'h9, "R2 mode=RC enable=1");
    apb_write(12'h000, 32'h0000_FFFF);
    @(negedge clk); chk(32'(dev_mode), 32'h4, "R1 no enable keeps mode");
    apb_write(12'h000, 32'h0004_0000);
    @(negedge clk); chk(32'({dev_mode, ltssm_en}), 32'h8, "R1 enable-only clears bit 2");
    apb_read(12'h000);

    // R3/R4: INTx masking
    intx_in = 4'b0101;
    @(negedge clk); chk(32'(irq), 0, "R4 all masked");
    apb_write(12'h01C, 32'h0001_0000);
    @(negedge clk); chk(32'(irq), 1, "R3 unmask bit0 raises irq");
    apb_read(12'h008); apb_read(12'h01C);
    apb_write(12'h01C, 32'h0001_0001);
    @(negedge clk); chk(32'(irq), 0, "R3 remask bit0");
    intx_in = 0;

    // R5: latched events, clear by write-back
    apb_write(12'h024, 32'h0006_0000);
    pulse_link();
    @(negedge clk); chk(32'(irq), 1, "R5 link change latched");
    apb_read(12'h010);
    apb_write(12'h010, 32'h0000_0002);
    @(negedge clk); chk(32'(irq), 0, "R5 write-back clears");
    // collision: clear commits on the same edge as a new rising edge
    fork
      apb_write(12'h010, 32'h0000_0002);
      begin @(posedge clk); @(posedge clk); #1 evt_link_chg = 1; @(posedge clk); #1 evt_link_chg = 0; end
    join
    apb_read(12'h010);
    @(negedge clk); chk(32'(irq), 1, "R5 set wins over clear");
    apb_write(12'h010, 32'h0000_0006);

    // R7/R8: training hold
    apb_write(12'h180, 32'h0012_0012);
    apb_write(12'h000, 32'h0004_0004);
    pulse_rst();
    @(negedge clk); chk(32'({train_hold, ltssm_go}), 32'h2, "R7 hold blocks training");
    apb_read(12'h180);
    apb_write(12'h180, 32'h0008_0008);
    @(negedge clk); chk(32'({train_hold, ltssm_go}), 32'h1, "R8 done releases hold");
    pulse_rst();
    fork
      apb_write(12'h180, 32'h0008_0008);
      begin @(posedge clk); @(posedge clk); #1 evt_rst_req = 1; @(posedge clk); #1 evt_rst_req = 0; end
    join
    @(negedge clk); chk(32'(train_hold), 1, "R8 new request with done keeps hold");
    apb_write(12'h180, 32'h0008_0008);
    apb_write(12'h180, 32'h0002_0000);
    pulse_rst();
    @(negedge clk); chk(32'(train_hold), 0, "R7 no hold when delay disabled");

    // R6/R9: status words and power control
    ltssm_state = 6'h11; link_bits = 2'b11; l1_1_res = 1;
    apb_read(12'h300); apb_read(12'h154);
    link_bits = 2'b10; l1_1_res = 0; l1_2_res = 1;
    @(negedge clk); chk(32'(link_up), 0, "R6 one link bit is not up");
    apb_read(12'h300); apb_read(12'h154);
    apb_write(12'h02C, 32'h3001_1001);
    @(negedge clk); chk(32'({clkreq_pd, clkreq_ready}), 32'h3, "R9 clkreq fields");

    // R10: unmapped offsets
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_write(12'h200, 32'hFFFF_FFFF);
    read_all();

    // mixed traffic with events landing on write edges
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 9))
        0: a = 12'h000; 1: a = 12'h010; 2: a = 12'h01C; 3: a = 12'h024;
        4: a = 12'h02C; 5: a = 12'h180; 6: a = 12'h154; 7: a = 12'h300;
        8: a = 12'h008; default: a = 12'h0F0;
      endcase
      intx_in = 4'($urandom);
      ltssm_state = 6'($urandom); link_bits = 2'($urandom);
      l1_1_res = 1'($urandom); l1_2_res = 1'($urandom);
      fork
        if ($urandom_range(0, 1) == 1) apb_write(a, $urandom); else apb_read(a);
        begin
          @(posedge clk); @(posedge clk); #1;
          evt_link_chg = 1'($urandom); evt_rst_req = 1'($urandom);
        end
      join
    end
    read_all();

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule